// File: doc/BRIEF.md
# Internal Data RAM Access Unit

This unit holds the 256-byte scratch memory of an 8-bit microcontroller. It applies the addressing rules that decide what each request reaches. A request names an addressing mode, an address, the two register-bank bits and, for writes, a data byte. The unit turns that request into an access to one RAM byte, or into a strobe toward the special-function-register space. That space lives outside this block.

Byte addresses in the lower half can be reached in every mode. The upper half behaves differently by mode. An indirect access reaches RAM there. A direct access to the same address leaves RAM untouched and raises an SFR read or write strobe that carries the address and data. Register operands are folded into one of four eight-byte banks at the bottom of memory. Bit operations reach a 16-byte window just above the banks. A bit write is done as a read followed by a write-back, and the unit reports busy while the write-back is pending.

Top module: `iram_access_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o`, `rd_valid_o`, `sfr_rd_o` and `sfr_wr_o` are all 0.
- R2: With `req_mode`=00 (direct), an accepted access to 00h–7Fh reaches RAM. A write (`req_wr`=1) stores `req_wdata`. A read (`req_wr`=0) raises `rd_valid_o` for one cycle on the next clock, with the byte on `rd_data_o`.
- R3: With `req_mode`=01 (indirect), every address 00h–FFh reaches RAM for reads and writes, with the same one-cycle read latency as R2.
- R4: With `req_mode`=00 and address 80h–FFh, the unit raises `sfr_wr_o` (write) or `sfr_rd_o` (read) in the same cycle. `sfr_addr_o` carries the address and `sfr_wdata_o` carries the data. RAM is not changed and no `rd_valid_o` follows.
- R5: With `req_mode`=10 (register), `req_addr[2:0]` selects R0–R7 and the RAM byte is `{3'b000, req_bank, req_addr[2:0]}`. This places bank 0 at 00h–07h, bank 1 at 08h–0Fh, bank 2 at 10h–17h and bank 3 at 18h–1Fh.
- R6: With `req_mode`=11 (bit), bit address b=`req_addr[6:0]` selects byte 20h + b[6:3] and bit position b[2:0]. `req_addr[7]` has no effect.
- R7: A bit read returns the selected bit in `rd_data_o[0]` with bits 7:1 zero, one cycle after the request.
- R8: A bit write sets the selected bit to `req_wdata[0]` and leaves the other seven bits of that byte unchanged. `busy_o` is 1 for exactly the one cycle after the request.
- R9: A request made while `busy_o` is 1 is ignored: no RAM change, no strobe, no read response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 00 direct, 01 indirect, 10 register, 11 bit |
| req_addr | input | 8 | Byte address, register number or bit address |
| req_bank | input | 2 | Register-bank select |
| req_wdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| busy_o | output | 1 | Bit write-back in progress; requests ignored |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 8 | Read response data |
| sfr_rd_o | output | 1 | SFR read strobe |
| sfr_wr_o | output | 1 | SFR write strobe |
| sfr_addr_o | output | 8 | SFR address |
| sfr_wdata_o | output | 8 | SFR write data |

## Verification
Several internal faults show up at the ports. If the write-back flag sticks, `busy_o` stays high and the following request is dropped, so the next read response goes missing within two cycles. A wrong bit position or base address held in the write-back registers corrupts a neighbouring bit. That fault only appears when the byte is read back through a direct or bit read one cycle later. A wrong bank or mode decode steers a write to the wrong byte or raises a stray SFR strobe. The strobe shows in the cycle of the request, and the misplaced write shows on the later indirect read of the expected address.

// File: rtl/iram_pkg.sv
package iram_pkg;

   typedef enum logic [1:0] {
      AM_DIRECT   = 2'b00,
      AM_INDIRECT = 2'b01,
      AM_REGISTER = 2'b10,
      AM_BIT      = 2'b11
   } acc_mode_e;

endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map
   import iram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BANK_W = 2,
   parameter int REG_W  = 3,
   parameter int POS_W  = 3,
   parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
   input  acc_mode_e          mode_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [BANK_W-1:0]  bank_i,
   output logic [ADDR_W-1:0]  ram_addr_o,
   output logic [POS_W-1:0]   bit_pos_o,
   output logic               is_sfr_o
);

   localparam int WIN_W = ADDR_W - 1 - POS_W;

   if (BANK_W + REG_W >= ADDR_W) begin : g_bad_bank
      $error("bank and register fields exceed address width");
   end
   if (WIN_W < 1) begin : g_bad_win
      $error("bit window too narrow");
   end

   logic [ADDR_W-1:0] reg_addr;
   logic [ADDR_W-1:0] bit_byte;

   assign reg_addr = ADDR_W'({bank_i, addr_i[REG_W-1:0]});
   assign bit_byte = BIT_BASE + ADDR_W'(addr_i[ADDR_W-2:POS_W]);

   always_comb begin
      is_sfr_o  = 1'b0;
      bit_pos_o = addr_i[POS_W-1:0];
      unique case (mode_i)
         AM_DIRECT: begin
            ram_addr_o = addr_i;
            is_sfr_o   = addr_i[ADDR_W-1];
         end
         AM_INDIRECT: ram_addr_o = addr_i;
         AM_REGISTER: ram_addr_o = reg_addr;
         default:     ram_addr_o = bit_byte;
      endcase
   end

endmodule

// File: rtl/iram_bit_merge.sv
module iram_bit_merge #(
   parameter int DATA_W = 8,
   parameter int POS_W  = 3
) (
   input  logic [DATA_W-1:0] byte_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic              val_i,
   output logic [DATA_W-1:0] byte_o
);

   if ((1 << POS_W) != DATA_W) begin : g_bad_pos
      $error("position width does not match data width");
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign byte_o[i] = (pos_i == POS_W'(i)) ? val_i : byte_i[i];
   end

endmodule

// File: rtl/iram_store.sv
module iram_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
      if (re_i) rdata_o <= mem[raddr_i];
   end

endmodule

// File: rtl/iram_access_unit.sv
module iram_access_unit
   import iram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int BANK_W = 2,
   parameter int REG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_wr,
   input  logic [1:0]        req_mode,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy_o,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              sfr_rd_o,
   output logic              sfr_wr_o,
   output logic [ADDR_W-1:0] sfr_addr_o,
   output logic [DATA_W-1:0] sfr_wdata_o
);

   localparam int POS_W = $clog2(DATA_W);

   if (DATA_W < 2) begin : g_bad_data
      $error("data width too small");
   end

   acc_mode_e         mode;
   logic              accept, is_bit, is_sfr;
   logic [ADDR_W-1:0] ram_addr;
   logic [POS_W-1:0]  bit_pos;

   logic              wb_pend;
   logic [ADDR_W-1:0] wb_addr;
   logic [POS_W-1:0]  wb_pos;
   logic              wb_val;
   logic              rd_bit_q;
   logic [POS_W-1:0]  rd_pos_q;

   logic              st_we, st_re;
   logic [ADDR_W-1:0] st_waddr;
   logic [DATA_W-1:0] st_wdata, st_rdata, merged;

   assign mode   = acc_mode_e'(req_mode);
   assign busy_o = wb_pend;
   assign accept = req_valid & ~wb_pend;
   assign is_bit = (mode == AM_BIT);

   iram_addr_map #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .REG_W  (REG_W),
      .POS_W  (POS_W)
   ) u_map (
      .mode_i     (mode),
      .addr_i     (req_addr),
      .bank_i     (req_bank),
      .ram_addr_o (ram_addr),
      .bit_pos_o  (bit_pos),
      .is_sfr_o   (is_sfr)
   );

   iram_bit_merge #(
      .DATA_W (DATA_W),
      .POS_W  (POS_W)
   ) u_merge (
      .byte_i (st_rdata),
      .pos_i  (wb_pos),
      .val_i  (wb_val),
      .byte_o (merged)
   );

   assign st_re    = accept & ~is_sfr & (~req_wr | is_bit);
   assign st_we    = wb_pend | (accept & req_wr & ~is_sfr & ~is_bit);
   assign st_waddr = wb_pend ? wb_addr : ram_addr;
   assign st_wdata = wb_pend ? merged : req_wdata;

   iram_store #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_store (
      .clk     (clk),
      .we_i    (st_we),
      .waddr_i (st_waddr),
      .wdata_i (st_wdata),
      .re_i    (st_re),
      .raddr_i (ram_addr),
      .rdata_o (st_rdata)
   );

   assign sfr_rd_o    = accept & is_sfr & ~req_wr;
   assign sfr_wr_o    = accept & is_sfr & req_wr;
   assign sfr_addr_o  = req_addr;
   assign sfr_wdata_o = req_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_pend    <= 1'b0;
         wb_addr    <= '0;
         wb_pos     <= '0;
         wb_val     <= 1'b0;
         rd_valid_o <= 1'b0;
         rd_bit_q   <= 1'b0;
         rd_pos_q   <= '0;
      end else begin
         wb_pend    <= accept & req_wr & is_bit;
         rd_valid_o <= accept & ~req_wr & ~is_sfr;
         if (accept) begin
            wb_addr  <= ram_addr;
            wb_pos   <= bit_pos;
            wb_val   <= req_wdata[0];
            rd_bit_q <= is_bit;
            rd_pos_q <= bit_pos;
         end
      end
   end

   assign rd_data_o = rd_bit_q ? DATA_W'(st_rdata[rd_pos_q]) : st_rdata;

   a_r4_sfr_read_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_rd_o |=> !rd_valid_o);

   a_r8_busy_after_bitwr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy_o && req_wr && req_mode == 2'b11) |=> busy_o);

   a_r8_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !busy_o);

   a_r9_no_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !(sfr_rd_o || sfr_wr_o));

   a_r2_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(req_valid && !req_wr && !busy_o));

endmodule

// File: tb/iram_access_unit_tb.sv
module iram_access_unit_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       req_valid, req_wr;
   logic [1:0] req_mode, req_bank;
   logic [7:0] req_addr, req_wdata;
   logic       busy_o, rd_valid_o, sfr_rd_o, sfr_wr_o;
   logic [7:0] rd_data_o, sfr_addr_o, sfr_wdata_o;

   typedef struct {
      logic [7:0] data;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   logic [7:0] model [256];
   int         checks = 0;
   int         fails  = 0;
   bit         done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   iram_access_unit u_dut (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_wr (req_wr),
      .req_mode (req_mode), .req_addr (req_addr), .req_bank (req_bank),
      .req_wdata (req_wdata), .busy_o (busy_o), .rd_valid_o (rd_valid_o),
      .rd_data_o (rd_data_o), .sfr_rd_o (sfr_rd_o), .sfr_wr_o (sfr_wr_o),
      .sfr_addr_o (sfr_addr_o), .sfr_wdata_o (sfr_wdata_o)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] eff_addr(input logic [1:0] mode,
                                           input logic [7:0] addr,
                                           input logic [1:0] bank);
      case (mode)
         2'b10:   return {3'b000, bank, addr[2:0]};
         2'b11:   return 8'h20 + {4'h0, addr[6:3]};
         default: return addr;
      endcase
   endfunction

   task automatic drive(input logic [1:0] mode, input bit wr,
                        input logic [7:0] addr, input logic [1:0] bank,
                        input logic [7:0] wd, input string tag);
      logic [7:0] ea;
      bit         sfr;
      @(negedge clk);
      req_mode  = mode;
      req_wr    = wr;
      req_addr  = addr;
      req_bank  = bank;
      req_wdata = wd;
      req_valid = 1'b1;
      ea  = eff_addr(mode, addr, bank);
      sfr = (mode == 2'b00) && addr[7];
      #1;
      check(sfr_wr_o == (sfr && wr), {tag, " R4 sfr_wr"}, 8'(sfr_wr_o), 8'(sfr && wr));
      check(sfr_rd_o == (sfr && !wr), {tag, " R4 sfr_rd"}, 8'(sfr_rd_o), 8'(sfr && !wr));
      if (sfr) begin
         check(sfr_addr_o == addr, {tag, " R4 sfr_addr"}, sfr_addr_o, addr);
         if (wr) check(sfr_wdata_o == wd, {tag, " R4 sfr_wdata"}, sfr_wdata_o, wd);
      end else if (!wr) begin
         if (mode == 2'b11) sb.push_back('{{7'b0, model[ea][addr[2:0]]}, tag});
         else               sb.push_back('{model[ea], tag});
      end else if (mode == 2'b11) begin
         model[ea][addr[2:0]] = wd[0];
      end else begin
         model[ea] = wd;
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (sfr && !wr) check(rd_valid_o == 1'b0, {tag, " R4 no response"}, 8'(rd_valid_o), 8'h00);
      if (wr && mode == 2'b11) begin
         check(busy_o == 1'b1, {tag, " R8 busy high"}, 8'(busy_o), 8'h01);
         @(negedge clk);
         check(busy_o == 1'b0, {tag, " R8 busy low"}, 8'(busy_o), 8'h00);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n === 1'b1 && rd_valid_o === 1'b1) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2 unexpected rd_valid", rd_data_o, 8'h00);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(rd_data_o === e.data, e.tag, rd_data_o, e.data);
         end
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         check(1'b0, "watchdog expired", 8'h00, 8'h01);
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_wr = 1'b0; req_mode = 2'b00;
      req_addr = 8'h00; req_bank = 2'b00; req_wdata = 8'h00;
      repeat (3) @(negedge clk);
      check(busy_o == 0 && rd_valid_o == 0, "R1 reset busy/rd_valid", {6'b0, busy_o, rd_valid_o}, 8'h00);
      check(sfr_rd_o == 0 && sfr_wr_o == 0, "R1 reset strobes", {6'b0, sfr_rd_o, sfr_wr_o}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_o == 0 && rd_valid_o == 0, "R1 after reset", {6'b0, busy_o, rd_valid_o}, 8'h00);

      // R2 direct lower half
      drive(2'b00, 1, 8'h30, 2'b00, 8'hA5, "R2 wr 30");
      drive(2'b00, 1, 8'h7F, 2'b00, 8'h3C, "R2 wr 7F");
      drive(2'b00, 1, 8'h35, 2'b00, 8'h77, "R2 wr 35");
      drive(2'b00, 0, 8'h30, 2'b00, 8'h00, "R2 rd 30");
      drive(2'b00, 0, 8'h7F, 2'b00, 8'h00, "R2 rd 7F");

      // R3 indirect upper half
      drive(2'b01, 1, 8'h80, 2'b00, 8'h5A, "R3 wr 80");
      drive(2'b01, 1, 8'hFF, 2'b00, 8'hC3, "R3 wr FF");
      drive(2'b01, 0, 8'h80, 2'b00, 8'h00, "R3 rd 80");
      drive(2'b01, 0, 8'hFF, 2'b00, 8'h00, "R3 rd FF");
      drive(2'b01, 0, 8'h30, 2'b00, 8'h00, "R3 rd 30");

      // R4 direct upper half goes to SFR, RAM untouched
      drive(2'b00, 1, 8'h80, 2'b00, 8'h11, "R4 sfr wr 80");
      drive(2'b00, 1, 8'hFF, 2'b00, 8'h22, "R4 sfr wr FF");
      drive(2'b00, 0, 8'h90, 2'b00, 8'h00, "R4 sfr rd 90");
      drive(2'b01, 0, 8'h80, 2'b00, 8'h00, "R4 ram 80 kept");
      drive(2'b01, 0, 8'hFF, 2'b00, 8'h00, "R4 ram FF kept");

      // R5 register banks
      for (int b = 0; b < 4; b++) begin
         drive(2'b10, 1, 8'(2 * b + 1), 2'(b), 8'(8'h40 + b), "R5 reg wr");
         drive(2'b10, 1, 8'h07, 2'(b), 8'(8'hE0 + b), "R5 reg wr R7");
      end
      for (int b = 0; b < 4; b++) begin
         drive(2'b01, 0, 8'(8 * b + 2 * b + 1), 2'b00, 8'h00, "R5 bank byte via indirect");
         drive(2'b10, 0, 8'h07, 2'(b), 8'h00, "R5 reg rd R7");
      end

      // R6/R7/R8 bit window
      for (int a = 8'h20; a < 8'h30; a++) drive(2'b00, 1, 8'(a), 2'b00, 8'h00, "R6 clear window");
      drive(2'b11, 1, 8'h0B, 2'b00, 8'h01, "R8 set bit 0B");
      drive(2'b00, 0, 8'h21, 2'b00, 8'h00, "R6 byte 21 after 0B");
      drive(2'b11, 1, 8'h0A, 2'b00, 8'hFF, "R8 set bit 0A");
      drive(2'b11, 1, 8'h0B, 2'b00, 8'hFE, "R8 clear bit 0B");
      drive(2'b00, 0, 8'h21, 2'b00, 8'h00, "R8 neighbours kept 21");
      drive(2'b11, 1, 8'h7F, 2'b00, 8'h01, "R6 set bit 7F");
      drive(2'b00, 0, 8'h2F, 2'b00, 8'h00, "R6 byte 2F");
      drive(2'b11, 1, 8'h85, 2'b00, 8'h01, "R6 addr bit7 ignored");
      drive(2'b00, 0, 8'h20, 2'b00, 8'h00, "R6 byte 20 bit5");
      drive(2'b11, 0, 8'h0A, 2'b00, 8'h00, "R7 bit read 0A");
      drive(2'b11, 0, 8'h0B, 2'b00, 8'h00, "R7 bit read 0B");
      drive(2'b11, 0, 8'h7F, 2'b00, 8'h00, "R7 bit read 7F");

      // R9 requests during busy are ignored
      @(negedge clk);
      req_mode = 2'b11; req_wr = 1; req_addr = 8'h10; req_wdata = 8'h01; req_valid = 1;
      model[8'h22][0] = 1'b1;
      @(negedge clk);
      req_mode = 2'b00; req_wr = 1; req_addr = 8'h35; req_wdata = 8'hEE;
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);
      req_mode = 2'b11; req_wr = 1; req_addr = 8'h11; req_wdata = 8'h01; req_valid = 1;
      model[8'h22][1] = 1'b1;
      @(negedge clk);
      req_mode = 2'b00; req_wr = 1; req_addr = 8'hA0; req_wdata = 8'h55;
      #1;
      check(sfr_wr_o == 1'b0, "R9 no sfr strobe while busy", 8'(sfr_wr_o), 8'h00);
      @(negedge clk);
      req_valid = 0;
      drive(2'b00, 0, 8'h35, 2'b00, 8'h00, "R9 byte 35 unchanged");
      drive(2'b00, 0, 8'h22, 2'b00, 8'h00, "R9 byte 22 bits set");

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R2 all responses seen", 8'(sb.size()), 8'h00);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule